// File: doc/BRIEF.md
# SHA-256 Message Schedule Update Unit

This block extends a SHA-256 message schedule by four words per pass. Each schedule word is 32 bits, and four of them are packed into a 128-bit operand. Lane 0 sits in bits 31:0 and lane 3 in bits 127:96.

The recurrence is split into two passes, chosen by `part_sel`:

- **First pass** (`part_sel` = 0): the block folds the small-sigma0 term into words w0..w3, using w4 as the neighbour of the top lane.
- **Second pass** (`part_sel` = 1): the block takes the first pass's result as `op_a`, together with w8..w11 and w12..w15. It adds the small-sigma1 terms. The two upper lanes of this result depend on the two lower lanes of the same result, so they form a chain inside one evaluation.

Both passes are combinational. They feed a small output stage with two named states:

- `ST_EMPTY`: no result held.
- `ST_FULL`: a result is held on `out_word`.

The stage has two transitions:

- `CAPTURE`: taken from either state on a clock edge where `in_valid` is high. The stage moves to `ST_FULL` and loads the new result.
- `DRAIN`: taken from either state on a clock edge where `in_valid` is low. The stage moves to `ST_EMPTY` and keeps the old word.

`out_valid` is high exactly in `ST_FULL`. Setting the parameter `REG_OUT` to 0 replaces the stage with a direct path.

Top module: `msg_sched_unit`

## Requirements
- R1: After reset, and before any accepted input, `out_valid` is 0 and `out_word` is all zeros.
- R2: With `part_sel`=0, result lanes 0..2 equal `op_a` lane i plus sig0(`op_a` lane i+1), where sig0(x) = ror(x,7) ^ ror(x,18) ^ (x >> 3).
- R3: With `part_sel`=0, result lane 3 equals `op_a` lane 3 plus sig0(`op_b` lane 0). `op_c` and `op_b` lanes 1..3 have no effect on the result.
- R4: With `part_sel`=1, result lanes 0 and 1 equal `op_a` lane i plus `op_b` lane i+1 plus sig1(`op_c` lane i+2), where sig1(x) = ror(x,17) ^ ror(x,19) ^ (x >> 10).
- R5: With `part_sel`=1, result lane 2 equals `op_a` lane 2 plus `op_b` lane 3 plus sig1(result lane 0).
- R6: With `part_sel`=1, result lane 3 equals `op_a` lane 3 plus `op_c` lane 0 plus sig1(result lane 1).
- R7: Every lane sum wraps modulo 2^32, and no carry passes into a neighbouring lane.
- R8: With `REG_OUT`=1, `out_valid` is high in the cycle after each clock edge that sees `in_valid` high. It is low after an edge that sees `in_valid` low.
- R9: While `in_valid` is low, `out_word` keeps its last value, whatever the operands and `part_sel` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| part_sel | input | 1 | 0 = sigma0 pass, 1 = sigma1 pass |
| op_a | input | 128 | w0..w3, or the first pass result in the second pass |
| op_b | input | 128 | w4..w7 (first pass) or w8..w11 (second pass) |
| op_c | input | 128 | w12..w15 (second pass only) |
| out_valid | output | 1 | Result on `out_word` is valid |
| out_word | output | 128 | Four new schedule lanes, lane 0 in bits 31:0 |

## Verification
Both passes are applied to the following operand patterns, each chosen to expose a different fault:

- **All-zero operands**: prove that nothing leaks into the result.
- **A single set bit per lane**: shows whether each rotation and shift amount lands on the right bit position.
- **All-ones lanes**: force every sum to wrap. They expose a carry that crosses a lane boundary.
- **Mixed real-looking words**: catch a lane paired with the wrong neighbour.

For the second pass, one test changes only `op_c` lanes 2 and 3 and checks that the upper lanes move through the chain. A matching test for the first pass changes only `op_c` and the upper `op_b` lanes and checks that nothing moves. A final test drops `in_valid` and alters the operands to check the hold behaviour.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int LANE_W = 32;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_t;

    function automatic lane_t rotr(input lane_t x, input int n);
        return (x >> n) | (x << (LANE_W - n));
    endfunction

    function automatic lane_t sig0(input lane_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic lane_t sig1(input lane_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic lane_t lane_of(input word_t w, input int idx);
        return w[idx*LANE_W +: LANE_W];
    endfunction
endpackage

// File: rtl/sched_pass_lo.sv
module sched_pass_lo
    import sched_pkg::*;
(
    input  word_t src_a,
    input  word_t src_b,
    output word_t res
);
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            lane_t nbr;
            if (i < LANES - 1) begin : g_inner
                assign nbr = src_a[(i+1)*LANE_W +: LANE_W];
            end else begin : g_edge
                assign nbr = src_b[LANE_W-1:0];
            end
            assign res[i*LANE_W +: LANE_W] = src_a[i*LANE_W +: LANE_W] + sig0(nbr);
        end
    endgenerate
endmodule

// File: rtl/sched_pass_hi.sv
module sched_pass_hi
    import sched_pkg::*;
(
    input  word_t src_a,
    input  word_t src_b,
    input  word_t src_c,
    output word_t res
);
    localparam int HALF = LANES / 2;

    lane_t lane_r [LANES];

    generate
        for (genvar i = 0; i < HALF; i++) begin : g_lower
            assign lane_r[i] = src_a[i*LANE_W +: LANE_W]
                             + src_b[(i+1)*LANE_W +: LANE_W]
                             + sig1(src_c[(i+HALF)*LANE_W +: LANE_W]);
        end
        for (genvar i = HALF; i < LANES; i++) begin : g_upper
            lane_t addend;
            if (i < LANES - 1) begin : g_from_b
                assign addend = src_b[(i+1)*LANE_W +: LANE_W];
            end else begin : g_from_c
                assign addend = src_c[LANE_W-1:0];
            end
            assign lane_r[i] = src_a[i*LANE_W +: LANE_W] + addend + sig1(lane_r[i-HALF]);
        end
        for (genvar i = 0; i < LANES; i++) begin : g_pack
            assign res[i*LANE_W +: LANE_W] = lane_r[i];
        end
    endgenerate
endmodule

// File: rtl/sched_out_stage.sv
module sched_out_stage
    import sched_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  word_t d_in,
    output logic  q_valid,
    output word_t q_out
);
    generate
        if (REG_OUT) begin : g_reg
            stage_state_t state_q, state_d;
            word_t        data_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    state_q <= ST_EMPTY;
                end else begin
                    state_q <= state_d;
                end
            end

            always_comb begin
                unique case (state_q)
                    ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
                    ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
                    default:  state_d = ST_EMPTY;
                endcase
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    data_q <= '0;
                end else if (in_valid) begin
                    data_q <= d_in;
                end
            end

            always_comb begin
                q_valid = (state_q == ST_FULL);
                q_out   = data_q;
            end
        end else begin : g_comb
            always_comb begin
                q_valid = in_valid;
                q_out   = d_in;
            end
        end
    endgenerate
endmodule

// File: rtl/msg_sched_unit.sv
module msg_sched_unit
    import sched_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         part_sel,
    input  logic [127:0] op_a,
    input  logic [127:0] op_b,
    input  logic [127:0] op_c,
    output logic         out_valid,
    output logic [127:0] out_word
);
    word_t lo_res, hi_res, sel_res;

    sched_pass_lo u_lo (
        .src_a (op_a),
        .src_b (op_b),
        .res   (lo_res)
    );

    sched_pass_hi u_hi (
        .src_a (op_a),
        .src_b (op_b),
        .src_c (op_c),
        .res   (hi_res)
    );

    assign sel_res = part_sel ? hi_res : lo_res;

    sched_out_stage #(.REG_OUT(REG_OUT)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .d_in     (sel_res),
        .q_valid  (out_valid),
        .q_out    (out_word)
    );
endmodule

// File: rtl/msg_sched_unit_chk.sv
module msg_sched_unit_chk
    import sched_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         part_sel,
    input logic [127:0] op_a,
    input logic [127:0] op_b,
    input logic [127:0] op_c,
    input logic         out_valid,
    input logic [127:0] out_word
);
    generate
        if (REG_OUT) begin : g_seq
            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid); // R8
            AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid); // R8
            AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(out_word)); // R9
            AST_LO_TOP_LANE: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !part_sel) |=>
                    out_word[127:96] == $past(op_a[127:96]) + sig0($past(op_b[31:0]))); // R3
            AST_HI_LANE2_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && part_sel) |=>
                    out_word[95:64] == $past(op_a[95:64]) + $past(op_b[127:96])
                                       + sig1(out_word[31:0])); // R5
            AST_HI_LANE3_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && part_sel) |=>
                    out_word[127:96] == $past(op_a[127:96]) + $past(op_c[31:0])
                                        + sig1(out_word[63:32])); // R6
        end
    endgenerate
endmodule

bind msg_sched_unit msg_sched_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .part_sel  (part_sel),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_c      (op_c),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/msg_sched_unit_test.sv
module msg_sched_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         part_sel = 1'b0;
    logic [127:0] op_a = '0, op_b = '0, op_c = '0;
    logic         out_valid;
    logic [127:0] out_word;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    msg_sched_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .part_sel(part_sel),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .out_valid(out_valid), .out_word(out_word)
    );

    typedef struct packed {
        logic         part;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] c;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 128'h0, 128'h0, 128'h0},
        '{1'b0, 128'h00000001_00000001_00000001_00000001, 128'h00000000_00000000_00000000_00000001, 128'h0},
        '{1'b0, {4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, 128'h0},
        '{1'b0, 128'h61626380_00000000_12345678_9ABCDEF0, 128'h0F0F0F0F_F0F0F0F0_DEADBEEF_CAFEBABE, 128'h55555555_0_0_0},
        '{1'b1, 128'h0, 128'h0, 128'h0},
        '{1'b1, 128'h00000001_00000002_00000004_00000008, 128'h00000010_00000020_00000040_00000080, 128'h00000100_00000200_00000400_00000800},
        '{1'b1, {4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}},
        '{1'b1, 128'h89ABCDEF_01234567_DEADBEEF_CAFEBABE, 128'h11111111_22222222_33333333_44444444, 128'h80000000_00000018_0BADF00D_76543210}
    };

    function automatic logic [31:0] m_ror(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction
    function automatic logic [31:0] m_s0(input logic [31:0] x);
        return m_ror(x, 7) ^ m_ror(x, 18) ^ (x >> 3);
    endfunction
    function automatic logic [31:0] m_s1(input logic [31:0] x);
        return m_ror(x, 17) ^ m_ror(x, 19) ^ (x >> 10);
    endfunction

    function automatic logic [127:0] model(input logic p, input logic [127:0] a,
                                           input logic [127:0] b, input logic [127:0] c);
        logic [31:0] r [4];
        if (!p) begin
            r[0] = a[31:0]   + m_s0(a[63:32]);
            r[1] = a[63:32]  + m_s0(a[95:64]);
            r[2] = a[95:64]  + m_s0(a[127:96]);
            r[3] = a[127:96] + m_s0(b[31:0]);
        end else begin
            r[0] = a[31:0]   + b[63:32]  + m_s1(c[95:64]);
            r[1] = a[63:32]  + b[95:64]  + m_s1(c[127:96]);
            r[2] = a[95:64]  + b[127:96] + m_s1(r[0]);
            r[3] = a[127:96] + c[31:0]   + m_s1(r[1]);
        end
        return {r[3], r[2], r[1], r[0]};
    endfunction

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic p, input logic [127:0] a, input logic [127:0] b,
                         input logic [127:0] c, output logic [127:0] res, output logic v);
        @(negedge clk);
        part_sel = p; op_a = a; op_b = b; op_c = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        res = out_word;
        v = out_valid;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [127:0] r1, r2, held;
        logic v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {127'b0, out_valid}, 128'h0);
        check("R1 word", out_word, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle valid", {127'b0, out_valid}, 128'h0);

        // Table walk: R2 R3 (part 0), R4 R5 R6 (part 1), R7 wrap rows, R8 valid
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].part, VECS[i].a, VECS[i].b, VECS[i].c, r1, v);
            check(VECS[i].part ? "R4 R5 R6 R7 second pass" : "R2 R3 R7 first pass",
                  r1, model(VECS[i].part, VECS[i].a, VECS[i].b, VECS[i].c));
            check("R8 valid after accept", {127'b0, v}, 128'h1);
        end

        // R7: all-ones wrap, no cross-lane carry: first pass lane = FFFFFFFF + sig0(FFFFFFFF)
        apply(1'b0, {4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, '0, r1, v);
        check("R7 wrap", r1, {4{32'hFFFFFFFF + m_s0(32'hFFFFFFFF)}});

        // R3: op_c and op_b upper lanes have no effect in the first pass
        apply(1'b0, 128'h01020304_05060708_090A0B0C_0D0E0F10, 128'h0, 128'h0, r1, v);
        apply(1'b0, 128'h01020304_05060708_090A0B0C_0D0E0F10,
              128'hFFFFFFFF_ABCDEF01_76543210_00000000, {4{32'hA5A5A5A5}}, r2, v);
        check("R3 ignored operands", r2, r1);

        // R5 R6: changing only op_c lanes 2,3 moves the upper lanes via the chain
        apply(1'b1, 128'h0, 128'h0, 128'h00000000_00000000_0_0, r1, v);
        apply(1'b1, 128'h0, 128'h0, 128'h00400000_00200000_00000000_00000000, r2, v);
        check("R5 R6 chained", r2, model(1'b1, 128'h0, 128'h0, 128'h00400000_00200000_00000000_00000000));
        check("R5 upper lanes moved", {127'b0, r2[127:64] != r1[127:64]}, 128'h1);

        // R9 and R8: drop in_valid, disturb operands, output holds and valid falls
        held = r2;
        @(negedge clk);
        part_sel = 1'b0; op_a = {4{32'h13579BDF}}; op_b = {4{32'h2468ACE0}}; op_c = '1;
        @(negedge clk);
        check("R9 hold", out_word, held);
        check("R8 valid drops", {127'b0, out_valid}, 128'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule